// File: doc/BRIEF.md
# Post-Reset Drive Poll Interrupt Emulator

This block sits inside a floppy disk controller. It reproduces the interrupt that older controllers raised after a reset, when they polled their drives for a change in ready state. There are no drive ready inputs, and every drive counts as always ready. On the first clock edge after reset is released, the block marks every drive as having a ready-state change and raises its interrupt output. Software then clears the condition by issuing the Sense Interrupt Status command once per drive. Each command reports one drive, and the drives come out lowest-numbered first.

A poll-disable input switches the emulation off. If that input is high when the block leaves reset, nothing is marked pending and no interrupt is raised. Each accepted sense command produces its result bytes on `res_data` with `res_valid`, one byte per cycle, starting the cycle after the command strobe. Opcodes other than Sense Interrupt Status do not concern this block and are ignored.

Top module: `poll_irq_emu`

## Requirements
- R1: On the first rising clock edge after `rst_n` is released with `poll_dis` low, all four drives become pending and `irq` is high from that edge on. While `rst_n` is low, `irq` and `res_valid` are low.
- R2: If `poll_dis` is high at that first edge, no drive becomes pending and `irq` stays low. A later sense command returns the invalid status (R7).
- R3: `poll_dis` is looked at only on that first edge after reset. Changing it later does not alter the pending drives, `irq`, or the results.
- R4: A Sense Interrupt Status command is `cmd_valid` high with `cmd_op` = 08h. When a drive is pending, the block answers with two bytes. The first is ST0, valid the cycle after the strobe, with bits 7:6 = 11b (ready changed), bits 5:2 = 0 and bits 1:0 = drive number. The second is the present cylinder 00h, valid in the next cycle. `res_valid` is low in the cycle after that.
- R5: Pending drives are reported in ascending order: drive 0, 1, 2, then 3.
- R6: `irq` stays high while any drive is pending. It falls in the cycle after the strobe of the fourth accepted sense command, and never falls for any other reason except reset.
- R7: A sense command issued with nothing pending returns the single byte 80h (invalid command). `res_valid` is then low in the following cycle.
- R8: A strobe with any opcode other than 08h produces no result byte and leaves the pending drives and `irq` unchanged.
- R9: A strobe that arrives while result bytes are being driven (`res_valid` high) is ignored. It produces no result and consumes no pending drive.
- R10: Asserting `rst_n` low partway through the sequence restarts it. After release, all four drives are pending again and drive 0 is reported first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Controller reset, active low, asynchronous |
| poll_dis | input | 1 | Disables the poll emulation; sampled on the first edge after reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 8 | Command opcode; 08h is Sense Interrupt Status |
| res_valid | output | 1 | Result byte on `res_data` is valid |
| res_data | output | 8 | Result byte (ST0, then present cylinder) |
| irq | output | 1 | Interrupt request, high while any drive is pending |

## Verification
The assertions assume that `cmd_valid` is a single-cycle strobe and that `rst_n` is driven away from the clock edge. They also assume the drive number field of a reported ST0 indexes a real drive, which holds whenever there are four drives. The bench drives each strobe for exactly one cycle, between falling edges, and changes reset and `poll_dis` only on falling edges. The only strobes it sends while results are still being driven are the deliberate overlapping ones used to exercise R9. The random phase mixes sense commands, foreign opcodes, `poll_dis` toggles and resets, and checks each result against a model that counts the drives still pending.

// File: rtl/poll_emu_pkg.sv
package poll_emu_pkg;

   localparam int unsigned BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OP_SENSE_INT = 8'h08;
   localparam logic [1:0]        IC_READY_CHG = 2'b11;
   localparam logic [BYTE_W-1:0] ST0_INVALID  = 8'h80;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ST0  = 2'd1,
      SQ_CYL  = 2'd2
   } seq_state_t;

   function automatic logic [BYTE_W-1:0] make_st0(input logic [1:0] drv);
      return {IC_READY_CHG, 4'b0000, drv};
   endfunction

endpackage

// File: rtl/poll_pend_track.sv
module poll_pend_track #(
   parameter int unsigned N_DRIVES = 4,
   parameter int unsigned DRV_W    = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                poll_dis,
   input  logic                take,
   output logic [N_DRIVES-1:0] pend,
   output logic                any,
   output logic [DRV_W-1:0]    sel
);

   logic arm_q;

   // one-shot load on the first edge after reset release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b1;
      else        arm_q <= 1'b0;
   end

   for (genvar gi = 0; gi < N_DRIVES; gi++) begin : g_drive
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[gi] <= 1'b0;
         end else if (arm_q) begin
            pend[gi] <= ~poll_dis;
         end else if (take && (sel == DRV_W'(gi))) begin
            pend[gi] <= 1'b0;
         end
      end
   end

   // lowest-numbered pending drive wins
   always_comb begin
      sel = '0;
      for (int i = N_DRIVES - 1; i >= 0; i--) begin
         if (pend[i]) sel = DRV_W'(i);
      end
   end

   assign any = |pend;

endmodule

// File: rtl/poll_sense_seq.sv
module poll_sense_seq
   import poll_emu_pkg::*;
#(
   parameter int unsigned    DRV_W       = 2,
   parameter logic [BYTE_W-1:0] PRESENT_CYL = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [BYTE_W-1:0] cmd_op,
   input  logic              any,
   input  logic [DRV_W-1:0]  sel,
   output logic              take,
   output logic              res_valid,
   output logic [BYTE_W-1:0] res_data
);

   seq_state_t        state_q;
   logic [BYTE_W-1:0] byte_q;
   logic              two_q;
   logic              accept;
   logic              is_sense;

   assign is_sense = (cmd_op == OP_SENSE_INT);
   assign accept   = cmd_valid && (state_q == SQ_IDLE) && is_sense;
   assign take     = accept && any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         byte_q  <= '0;
         two_q   <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               if (accept) begin
                  state_q <= SQ_ST0;
                  two_q   <= any;
                  byte_q  <= any ? make_st0(2'(sel)) : ST0_INVALID;
               end
            end
            SQ_ST0: begin
               if (two_q) begin
                  state_q <= SQ_CYL;
                  byte_q  <= PRESENT_CYL;
               end else begin
                  state_q <= SQ_IDLE;
                  byte_q  <= '0;
               end
            end
            default: begin
               state_q <= SQ_IDLE;
               byte_q  <= '0;
               two_q   <= 1'b0;
            end
         endcase
      end
   end

   assign res_valid = (state_q != SQ_IDLE);
   assign res_data  = byte_q;

endmodule

// File: rtl/poll_irq_emu.sv
module poll_irq_emu
   import poll_emu_pkg::*;
#(
   parameter int unsigned N_DRIVES    = 4,
   parameter logic [7:0]  PRESENT_CYL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       poll_dis,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_op,
   output logic       res_valid,
   output logic [7:0] res_data,
   output logic       irq
);

   localparam int unsigned DRV_W = (N_DRIVES > 1) ? $clog2(N_DRIVES) : 1;

   if (N_DRIVES < 1 || N_DRIVES > 4) begin : g_bad_drives
      $error("poll_irq_emu: N_DRIVES must be 1..4 to fit the ST0 drive field");
   end

   logic [N_DRIVES-1:0] pend_w;
   logic                any_w;
   logic [DRV_W-1:0]    sel_w;
   logic                take_w;

   poll_pend_track #(
      .N_DRIVES (N_DRIVES),
      .DRV_W    (DRV_W)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .poll_dis (poll_dis),
      .take     (take_w),
      .pend     (pend_w),
      .any      (any_w),
      .sel      (sel_w)
   );

   poll_sense_seq #(
      .DRV_W       (DRV_W),
      .PRESENT_CYL (PRESENT_CYL)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .any       (any_w),
      .sel       (sel_w),
      .take      (take_w),
      .res_valid (res_valid),
      .res_data  (res_data)
   );

   assign irq = any_w;

endmodule

// File: rtl/poll_irq_emu_chk.sv
module poll_irq_emu_chk #(
   parameter int unsigned N_DRIVES = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_valid,
   input logic [7:0]          cmd_op,
   input logic                res_valid,
   input logic [7:0]          res_data,
   input logic                irq,
   input logic [N_DRIVES-1:0] pend,
   input logic                take
);

   function automatic logic [N_DRIVES-1:0] below(input logic [1:0] d);
      logic [N_DRIVES-1:0] m;
      for (int i = 0; i < N_DRIVES; i++) m[i] = (i < int'(d));
      return m;
   endfunction

   a_r1_rise_all_pending: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($countones(pend) == N_DRIVES));

   a_r4_cyl_after_st0: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_data[7:6] == 2'b11) |=> (res_valid && res_data == 8'h00));

   a_r5_lower_drives_done: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_data[7:6] == 2'b11) |-> ((pend & below(res_data[1:0])) == '0));

   a_r6_irq_falls_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(take));

   a_r7_invalid_one_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_data == 8'h80) |=> !res_valid);

   a_r8_foreign_op_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op != 8'h08 && irq) |=> $stable(pend));

   a_r9_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !take);

endmodule

bind poll_irq_emu poll_irq_emu_chk #(.N_DRIVES(N_DRIVES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .res_valid (res_valid),
   .res_data  (res_data),
   .irq       (irq),
   .pend      (pend_w),
   .take      (take_w)
);

// File: tb/poll_irq_emu_bench.sv
`timescale 1ns/1ps
module poll_irq_emu_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       poll_dis = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_op = 8'h00;
   logic       res_valid;
   logic [7:0] res_data;
   logic       irq;

   int total = 0;
   int bad = 0;
   int cnt = 0;   // model: drives still pending

   always #2.5 clk = ~clk;

   poll_irq_emu u_poll_irq_emu (
      .clk       (clk),
      .rst_n     (rst_n),
      .poll_dis  (poll_dis),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .res_valid (res_valid),
      .res_data  (res_data),
      .irq       (irq)
   );

   function automatic logic [7:0] exp_st0(input int pending);
      if (pending == 0) return 8'h80;
      return {2'b11, 4'b0000, 2'(4 - pending)};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input bit dis);
      @(negedge clk);
      rst_n = 1'b0;
      poll_dis = dis;
      cmd_valid = 1'b0;
      @(negedge clk);
      chk(irq == 1'b0, "R1 irq low in reset", irq, 0);
      chk(res_valid == 1'b0, "R1 no result in reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cnt = dis ? 0 : 4;
      chk(irq == !dis, dis ? "R2 no irq when disabled" : "R1 irq after reset", irq, !dis);
   endtask

   // issue one command; poke = strobe again while the first result byte shows
   task automatic issue(input logic [7:0] op, input bit poke, input bit dis_rand);
      logic [7:0] e;
      bit         two;
      int         pre;
      pre = cnt;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = op;
      if (dis_rand) poll_dis = 1'($urandom);
      @(negedge clk);
      cmd_valid = poke;
      cmd_op = 8'h08;
      if (op == 8'h08) begin
         e = exp_st0(cnt);
         two = (cnt > 0);
         if (cnt > 0) cnt--;
         chk(res_valid == 1'b1, "R4 result valid", res_valid, 1);
         chk(res_data == e, two ? "R5 ST0 drive order" : "R7 invalid ST0", res_data, e);
         chk(irq == (cnt > 0), "R6 irq tracks pending", irq, cnt > 0);
         @(negedge clk);
         cmd_valid = 1'b0;
         if (two) begin
            chk(res_valid && res_data == 8'h00, "R4 cylinder byte", res_data, 0);
            @(negedge clk);
         end
         chk(res_valid == 1'b0, poke ? "R9 overlap ignored" : "R7 result ends", res_valid, 0);
      end else begin
         cmd_valid = 1'b0;
         chk(res_valid == 1'b0, "R8 foreign op no result", res_valid, 0);
         chk(irq == (pre > 0), "R8 foreign op keeps irq", irq, pre > 0);
         @(negedge clk);
         chk(res_valid == 1'b0, "R8 foreign op still silent", res_valid, 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog R1-related run hung actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7731));
      repeat (3) @(negedge clk);
      // R1 reset and arm
      do_reset(1'b0);
      // R8 foreign opcode while pending
      issue(8'h03, 1'b0, 1'b0);
      issue(8'h0F, 1'b0, 1'b0);
      // R4 R5 R6 drain; last one overlapped (R9)
      issue(8'h08, 1'b0, 1'b0);
      issue(8'h08, 1'b1, 1'b0);
      issue(8'h08, 1'b0, 1'b0);
      issue(8'h08, 1'b1, 1'b0);
      // R7 nothing pending
      issue(8'h08, 1'b0, 1'b0);
      // R2 disabled at reset
      do_reset(1'b1);
      issue(8'h08, 1'b0, 1'b0);
      // R3 poll_dis toggled after the arm edge has no effect
      do_reset(1'b0);
      poll_dis = 1'b1;
      issue(8'h08, 1'b0, 1'b0);
      poll_dis = 1'b0;
      issue(8'h08, 1'b0, 1'b0);
      chk(cnt == 2 && irq == 1'b1, "R3 late poll_dis ignored", irq, 1);
      // R10 reset mid-sequence restarts at drive 0
      do_reset(1'b0);
      issue(8'h08, 1'b0, 1'b0);
      chk(cnt == 3, "R10 restart from drive 0", cnt, 3);
      // random mix
      for (int k = 0; k < 400; k++) begin
         int r;
         r = int'($urandom % 10);
         if (r == 0) begin
            do_reset(($urandom % 4) == 0);
         end else if (r < 3) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (op == 8'h08) op = 8'h09;
            issue(op, 1'b0, 1'b1);
         end else begin
            issue(8'h08, ($urandom % 4) == 0, 1'b1);
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule